// File: doc/BRIEF.md
# Link Swing Calibration Controller

This block picks the supply-swing level for an on-chip link so that the link runs at the lowest swing it can carry without errors. The analog regulator, the delayed sampling clock and the wires themselves sit outside the block. Here they appear only as the level code the block drives and the sample buses it receives.

Calibration runs in two phases. In the test phase the controller drives worst-case crosstalk stimulus onto the link and checks the looped-back data. Every clean pass through the full stimulus set lowers the level by one step. The first failing pass moves the level back up one step, and the controller then hands over to the run phase. In the run phase every evaluated cycle compares the main sample of the link against a later shadow sample of the same wires. A disagreement is a timing warning, not lost data, so the controller answers it by raising the level one step. A long stretch of agreement lets the level drop one step again. After every level change, and before each test pass, the controller waits for the supply to settle before it judges errors again. If errors still appear at the top level, the controller raises a sticky fail flag.

Top module: `lvc_ctrl`

## Requirements
- R1: While reset is held, and in the cycle after it, the level is the maximum code (all ones), the mode is idle (code 0), the test pattern bus is zero and the fail flag is low.
- R2: A start pulse in idle moves the mode to test (code 1). A start pulse in any other mode is ignored, and the mode and level stay as they were.
- R3: A test pass drives one stimulus block for each wire, starting at bit 0 and moving upward. Each block holds six cases, in this order. Case 0: victim rises while the other wires fall. Case 1: victim falls while the others rise. Case 2: victim stays at 0 while the others rise. Case 3: victim stays at 0 while the others fall. Case 4: victim stays at 1 while the others rise. Case 5: victim stays at 1 while the others fall. Each case is two consecutive vectors, the starting values first and then the final values. The pattern bus is zero in every cycle in which no vector is driven.
- R4: The received bus is compared with the vector driven one cycle earlier. A single mismatch anywhere in a pass makes the pass fail.
- R5: After a clean pass, the level drops by one and a new pass begins. A clean pass at level 0 instead enters run mode (code 2) at level 0.
- R6: After a failing pass, the level rises by one and the controller enters run mode. A failing pass at the maximum level sets the fail flag, leaves the level at maximum and enters run mode.
- R7: Each test pass, each entry into run mode and each level change is followed by SETTLE cycles. During these cycles no vector is driven and the main and shadow samples are not compared.
- R8: In run mode, an evaluated cycle in which the main and shadow samples differ raises the level by one. At the maximum level it sets the fail flag and the level stays.
- R9: In run mode, CLEAN_LIMIT consecutive evaluated cycles without a mismatch lower the level by one, but never below 0. The count then restarts. A mismatch also restarts the count.
- R10: Once set, the fail flag stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin calibration (acted on only in idle) |
| rx_i | input | WIDTH | Link output during test, one cycle behind the driven vector |
| main_i | input | WIDTH | Main sample of the link in run mode |
| shadow_i | input | WIDTH | Delayed shadow sample of the same wires |
| level_o | output | LVL_W | Swing level code to the regulator |
| pat_o | output | WIDTH | Test stimulus driven onto the link |
| mode_o | output | 2 | 0 idle, 1 test, 2 run |
| fail_o | output | 1 | Sticky: errors seen at the maximum level |

## Verification
The bench builds the block with WIDTH=4, SETTLE=4 and CLEAN_LIMIT=40. With these values a full test pass is 48 driven vectors, so a complete descent from the top code to level 0 fits in under a thousand cycles. The run-mode recovery window also becomes short enough to let the level drop and climb again several times in one run. The looped-back link fails below a threshold the bench can move, which places the end of calibration at a mid level, at the top level or at level 0. A one-cycle corruption of the received data, or a shadow mismatch injected inside or outside the settle window, exercises the single-error and masking corners.

// File: rtl/lvc_pkg.sv
package lvc_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_TEST = 2'd1,
        MODE_RUN  = 2'd2
    } lvc_mode_e;

    typedef enum logic [2:0] {
        MA_RISE_VS_FALL  = 3'd0,
        MA_FALL_VS_RISE  = 3'd1,
        MA_LOW_AGG_RISE  = 3'd2,
        MA_LOW_AGG_FALL  = 3'd3,
        MA_HIGH_AGG_RISE = 3'd4,
        MA_HIGH_AGG_FALL = 3'd5
    } ma_case_e;

    localparam logic [2:0] MA_LAST_CASE = 3'd5;

    // value on the victim wire and on every aggressor wire for one vector
    typedef struct packed {
        logic vic;
        logic agg;
    } ma_drive_t;

    function automatic ma_drive_t ma_drive(ma_case_e c, logic final_vec);
        ma_drive_t d;
        unique case (c)
            MA_RISE_VS_FALL:  d = '{vic: final_vec,  agg: ~final_vec};
            MA_FALL_VS_RISE:  d = '{vic: ~final_vec, agg: final_vec};
            MA_LOW_AGG_RISE:  d = '{vic: 1'b0,       agg: final_vec};
            MA_LOW_AGG_FALL:  d = '{vic: 1'b0,       agg: ~final_vec};
            MA_HIGH_AGG_RISE: d = '{vic: 1'b1,       agg: final_vec};
            MA_HIGH_AGG_FALL: d = '{vic: 1'b1,       agg: ~final_vec};
            default:          d = '{vic: 1'b0,       agg: 1'b0};
        endcase
        return d;
    endfunction

endpackage

// File: rtl/lvc_patgen.sv
module lvc_patgen
    import lvc_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             adv,
    output logic [WIDTH-1:0] pat,
    output logic             last
);
    localparam int VW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [VW-1:0] VIC_LAST = VW'(WIDTH - 1);

    logic [VW-1:0] vic_q;
    ma_case_e      case_q;
    logic          fin_q;
    ma_drive_t     drv;

    assign drv = ma_drive(case_q, fin_q);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        assign pat[b] = (vic_q == VW'(b)) ? drv.vic : drv.agg;
    end

    assign last = (vic_q == VIC_LAST) && (case_q == ma_case_e'(MA_LAST_CASE)) && fin_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            vic_q  <= '0;
            case_q <= MA_RISE_VS_FALL;
            fin_q  <= 1'b0;
        end else if (adv) begin
            fin_q <= ~fin_q;
            if (fin_q) begin
                if (case_q == ma_case_e'(MA_LAST_CASE)) begin
                    case_q <= MA_RISE_VS_FALL;
                    vic_q  <= (vic_q == VIC_LAST) ? '0 : vic_q + 1'b1;
                end else begin
                    case_q <= ma_case_e'(case_q + 3'd1);
                end
            end
        end
    end

    // R3: every driven vector has all aggressors equal
    assert_pattern_shape_R3: assert property (@(posedge clk) disable iff (rst)
        adv |-> ($countones(pat) <= 1 || $countones(pat) >= WIDTH - 1));

endmodule

// File: rtl/lvc_pass_chk.sv
module lvc_pass_chk #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             drv_valid,
    input  logic [WIDTH-1:0] drv_pat,
    input  logic [WIDTH-1:0] rx,
    output logic             bad
);
    logic [WIDTH-1:0] exp_q;
    logic             chk_q;
    logic             acc_q;
    logic             cur_mis;

    assign cur_mis = chk_q && (rx != exp_q);
    assign bad     = acc_q || cur_mis;

    always_ff @(posedge clk) begin
        if (rst) begin
            exp_q <= '0;
            chk_q <= 1'b0;
            acc_q <= 1'b0;
        end else begin
            exp_q <= drv_pat;
            chk_q <= drv_valid;
            if (clear)        acc_q <= 1'b0;
            else if (cur_mis) acc_q <= 1'b1;
        end
    end

    // R4: once a mismatch is seen the pass stays failed until cleared
    assert_bad_holds_R4: assert property (@(posedge clk) disable iff (rst)
        (bad && !clear) |=> bad);

endmodule

// File: rtl/lvc_shadow_mon.sv
module lvc_shadow_mon #(
    parameter int WIDTH       = 8,
    parameter int CLEAN_LIMIT = 1024
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             eval,
    input  logic [WIDTH-1:0] main_s,
    input  logic [WIDTH-1:0] shadow_s,
    output logic             mis,
    output logic             clean_hit
);
    localparam int CW = (CLEAN_LIMIT > 1) ? $clog2(CLEAN_LIMIT) : 1;
    localparam logic [CW-1:0] CNT_TOP = CW'(CLEAN_LIMIT - 1);

    logic [CW-1:0] cnt_q;

    assign mis       = eval && (main_s != shadow_s);
    assign clean_hit = eval && !mis && (cnt_q == CNT_TOP);

    always_ff @(posedge clk) begin
        if (rst || clear)               cnt_q <= '0;
        else if (eval) begin
            if (mis || clean_hit)       cnt_q <= '0;
            else                        cnt_q <= cnt_q + 1'b1;
        end
    end

    // R9: the clean run counter never passes its limit
    assert_count_bound_R9: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_TOP);

    // R9: a mismatch restarts the count
    assert_count_restart_R9: assert property (@(posedge clk) disable iff (rst)
        mis |=> cnt_q == '0);

endmodule

// File: rtl/lvc_ctrl.sv
module lvc_ctrl
    import lvc_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int LVL_W       = 4,
    parameter int SETTLE      = 16,
    parameter int CLEAN_LIMIT = 1024
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [WIDTH-1:0] rx_i,
    input  logic [WIDTH-1:0] main_i,
    input  logic [WIDTH-1:0] shadow_i,
    output logic [LVL_W-1:0] level_o,
    output logic [WIDTH-1:0] pat_o,
    output logic [1:0]       mode_o,
    output logic             fail_o
);
    localparam int WCW = $clog2(SETTLE + 1);
    localparam logic [WCW-1:0]   SETTLE_V = WCW'(SETTLE);
    localparam logic [LVL_W-1:0] LVL_MAX  = '1;

    lvc_mode_e        st_q;
    logic [LVL_W-1:0] lvl_q;
    logic [WCW-1:0]   wait_q;
    logic             drain_q;
    logic             fail_q;

    logic             settled, drive, decide, pass_restart, run_enter;
    logic [WIDTH-1:0] gen_pat;
    logic             gen_last, pass_bad, run_mis, run_hit;

    assign settled      = (wait_q == '0);
    assign drive        = (st_q == MODE_TEST) && settled && !drain_q;
    assign decide       = (st_q == MODE_TEST) && settled && drain_q;
    assign pass_restart = ((st_q == MODE_IDLE) && start_i)
                        || (decide && !pass_bad && lvl_q != '0);
    assign run_enter    = decide && (pass_bad || lvl_q == '0);

    lvc_patgen #(.WIDTH(WIDTH)) u_gen (
        .clk   (clk),
        .rst   (rst),
        .clear (pass_restart),
        .adv   (drive),
        .pat   (gen_pat),
        .last  (gen_last)
    );

    lvc_pass_chk #(.WIDTH(WIDTH)) u_chk (
        .clk       (clk),
        .rst       (rst),
        .clear     (pass_restart),
        .drv_valid (drive),
        .drv_pat   (pat_o),
        .rx        (rx_i),
        .bad       (pass_bad)
    );

    lvc_shadow_mon #(.WIDTH(WIDTH), .CLEAN_LIMIT(CLEAN_LIMIT)) u_mon (
        .clk       (clk),
        .rst       (rst),
        .clear     (run_enter),
        .eval      ((st_q == MODE_RUN) && settled),
        .main_s    (main_i),
        .shadow_s  (shadow_i),
        .mis       (run_mis),
        .clean_hit (run_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= MODE_IDLE;
            lvl_q   <= LVL_MAX;
            wait_q  <= '0;
            drain_q <= 1'b0;
            fail_q  <= 1'b0;
        end else begin
            unique case (st_q)
                MODE_IDLE: begin
                    if (start_i) begin
                        st_q    <= MODE_TEST;
                        wait_q  <= SETTLE_V;
                        drain_q <= 1'b0;
                    end
                end
                MODE_TEST: begin
                    if (!settled) begin
                        wait_q <= wait_q - 1'b1;
                    end else if (!drain_q) begin
                        if (gen_last) drain_q <= 1'b1;
                    end else begin
                        drain_q <= 1'b0;
                        wait_q  <= SETTLE_V;
                        if (!pass_bad) begin
                            if (lvl_q != '0) lvl_q <= lvl_q - 1'b1;
                            else             st_q  <= MODE_RUN;
                        end else begin
                            st_q <= MODE_RUN;
                            if (lvl_q == LVL_MAX) fail_q <= 1'b1;
                            else                  lvl_q  <= lvl_q + 1'b1;
                        end
                    end
                end
                MODE_RUN: begin
                    if (!settled) begin
                        wait_q <= wait_q - 1'b1;
                    end else if (run_mis) begin
                        if (lvl_q == LVL_MAX) begin
                            fail_q <= 1'b1;
                        end else begin
                            lvl_q  <= lvl_q + 1'b1;
                            wait_q <= SETTLE_V;
                        end
                    end else if (run_hit && lvl_q != '0) begin
                        lvl_q  <= lvl_q - 1'b1;
                        wait_q <= SETTLE_V;
                    end
                end
                default: st_q <= MODE_IDLE;
            endcase
        end
    end

    assign level_o = lvl_q;
    assign pat_o   = drive ? gen_pat : '0;
    assign mode_o  = st_q;
    assign fail_o  = fail_q;

    // R10: fail flag never clears outside reset
    assert_fail_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        fail_o |=> fail_o);

    // R5: level moves by at most one step per cycle
    assert_level_step_R5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (level_o == $past(level_o) || level_o == $past(level_o) + 1'b1
                  || level_o == $past(level_o) - 1'b1));

    // R7: level holds while the settle window runs
    assert_settle_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (wait_q != '0) |=> $stable(level_o));

    // R8: mismatch at the top level flags failure and keeps the level
    assert_max_mismatch_R8: assert property (@(posedge clk) disable iff (rst)
        (run_mis && level_o == LVL_MAX) |=> (fail_o && level_o == LVL_MAX));

    // R2: run mode is left only through reset
    assert_run_stays_R2: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'd2) |=> (mode_o == 2'd2));

endmodule

// File: tb/tb_lvc_ctrl.sv
module tb_lvc_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int W    = 4;
    localparam int LW   = 4;
    localparam int ST   = 4;
    localparam int CL   = 40;
    localparam int PLEN = W * 12;
    localparam int LMAX = 15;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [W-1:0]  rx_q = '0;
    logic [W-1:0]  main_d = '0;
    logic [W-1:0]  shadow_d;
    logic [LW-1:0] level_o;
    logic [W-1:0]  pat_o;
    logic [1:0]    mode_o;
    logic          fail_o;

    int  thr = 16;
    bit  rx_flip = 0;
    bit  sh_flip = 0;
    int  checks = 0;
    int  errs = 0;
    int  cyc = 0;
    bit  done = 0;
    bit  model_on = 0;

    // behavioural reference state
    int m_mode, m_lvl, m_fail, m_wait, m_pos, m_bad, m_clean, m_pv, m_prev;

    always #(CLK_PERIOD/2) clk = ~clk;

    lvc_ctrl #(.WIDTH(W), .LVL_W(LW), .SETTLE(ST), .CLEAN_LIMIT(CL)) dut (
        .clk(clk), .rst(rst), .start_i(start), .rx_i(rx_q),
        .main_i(main_d), .shadow_i(shadow_d),
        .level_o(level_o), .pat_o(pat_o), .mode_o(mode_o), .fail_o(fail_o)
    );

    assign shadow_d = main_d ^ {{(W-1){1'b0}}, sh_flip};

    // link: one cycle delay, bit 0 corrupted below the threshold level
    always @(posedge clk)
        rx_q <= pat_o ^ {{(W-1){1'b0}}, (int'(level_o) < thr) || rx_flip};

    always @(negedge clk) main_d <= W'(cyc * 5 + 3);

    function automatic int vec(int pos);
        int vi[6] = '{0, 1, 0, 0, 1, 1};
        int vf[6] = '{1, 0, 0, 0, 1, 1};
        int ai[6] = '{1, 0, 0, 1, 0, 1};
        int af[6] = '{0, 1, 1, 0, 1, 0};
        int victim = pos / 12;
        int c = (pos % 12) / 2;
        int fin = pos % 2;
        int r = 0;
        for (int b = 0; b < W; b++) begin
            int v;
            if (b == victim) v = fin ? vf[c] : vi[c];
            else             v = fin ? af[c] : ai[c];
            r = r | (v << b);
        end
        return r;
    endfunction

    function automatic int exp_pat();
        if (m_mode == 1 && m_wait == 0 && m_pos < PLEN) return vec(m_pos);
        return 0;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // reference model, advanced on every rising edge
    always @(posedge clk) begin
        cyc++;
        model_on <= 1'b1;
        if (rst) begin
            m_mode = 0; m_lvl = LMAX; m_fail = 0; m_wait = 0;
            m_pos = 0; m_bad = 0; m_clean = 0; m_pv = 0; m_prev = 0;
        end else begin
            case (m_mode)
                0: if (start) begin
                    m_mode = 1; m_wait = ST; m_pos = 0; m_bad = 0; m_pv = 0;
                end
                1: begin
                    int cur, dv;
                    if (m_pv != 0 && int'(rx_q) != m_prev) m_bad = 1;
                    dv  = (m_wait == 0 && m_pos < PLEN) ? 1 : 0;
                    cur = exp_pat();
                    m_pv = dv; m_prev = cur;
                    if (m_wait > 0) m_wait--;
                    else if (m_pos < PLEN) m_pos++;
                    else begin
                        m_wait = ST; m_pos = 0;
                        if (m_bad == 0 && m_lvl > 0) m_lvl--;
                        else begin
                            if (m_bad != 0) begin
                                if (m_lvl == LMAX) m_fail = 1; else m_lvl++;
                            end
                            m_mode = 2; m_clean = 0;
                        end
                        m_bad = 0;
                    end
                end
                default: begin
                    if (m_wait > 0) m_wait--;
                    else if (main_d != shadow_d) begin
                        m_clean = 0;
                        if (m_lvl == LMAX) m_fail = 1;
                        else begin m_lvl++; m_wait = ST; end
                    end else if (m_clean == CL - 1) begin
                        m_clean = 0;
                        if (m_lvl > 0) begin m_lvl--; m_wait = ST; end
                    end else m_clean++;
                end
            endcase
        end
        if (cyc > 150000 && !done) begin
            done = 1;
            checks++; errs++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    // cycle-by-cycle comparison against the model
    always @(negedge clk) if (model_on && !done) begin
        chk(int'(level_o) == m_lvl, "R5 R6 R8 R9", "level", int'(level_o), m_lvl);
        chk(int'(mode_o) == m_mode, "R2 R5", "mode", int'(mode_o), m_mode);
        chk(int'(pat_o) == exp_pat(), "R3 R7", "pattern", int'(pat_o), exp_pat());
        chk(int'(fail_o) == m_fail, "R10", "fail", int'(fail_o), m_fail);
    end

    task automatic wait_run(int limit);
        int n = 0;
        while (mode_o != 2'd2 && n < limit) begin @(negedge clk); n++; end
    endtask

    task automatic pulse_start();
        start = 1'b1; @(negedge clk); start = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1; repeat (3) @(negedge clk); rst = 1'b0;
    endtask

    initial begin
        int n;
        // scenario A: link fails below level 6
        repeat (3) @(negedge clk);
        chk(level_o == 4'hF && mode_o == 2'd0 && pat_o == '0 && fail_o == 1'b0,
            "R1", "reset state", int'(level_o), LMAX);
        thr = 6;
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(mode_o == 2'd0, "R2", "idle without start", int'(mode_o), 0);
        pulse_start();
        chk(mode_o == 2'd1, "R2", "test after start", int'(mode_o), 1);
        wait_run(2000);
        chk(mode_o == 2'd2 && level_o == 4'd6, "R5", "level after calibration", int'(level_o), 6);
        chk(fail_o == 1'b0, "R6", "no fail above top", int'(fail_o), 0);
        sh_flip = 1; repeat (2) @(negedge clk); sh_flip = 0;
        chk(level_o == 4'd6, "R7", "mismatch masked during settle", int'(level_o), 6);
        n = 0;
        while (level_o == 4'd6 && n < 200) begin @(negedge clk); n++; end
        chk(level_o == 4'd5, "R9", "drop after clean window", int'(level_o), 5);
        chk(n >= CL, "R9", "clean window length", n, CL);
        repeat (ST) @(negedge clk);
        sh_flip = 1; @(negedge clk); sh_flip = 0;
        chk(level_o == 4'd6, "R8", "raise on shadow mismatch", int'(level_o), 6);
        pulse_start();
        chk(mode_o == 2'd2 && level_o == 4'd6, "R2", "start ignored in run", int'(mode_o), 2);

        // scenario B: every level fails
        thr = 16;
        do_reset();
        pulse_start();
        wait_run(2000);
        chk(fail_o == 1'b1 && level_o == 4'hF, "R6", "fail at top level", int'(level_o), LMAX);
        repeat (ST + 1) @(negedge clk);
        sh_flip = 1; @(negedge clk); sh_flip = 0;
        chk(level_o == 4'hF && fail_o == 1'b1, "R8", "mismatch at top keeps level", int'(level_o), LMAX);
        n = 0;
        while (level_o == 4'hF && n < 200) begin @(negedge clk); n++; end
        chk(level_o == 4'd14, "R9", "drop from top", int'(level_o), 14);
        chk(fail_o == 1'b1, "R10", "fail stays set", int'(fail_o), 1);

        // scenario C: link never fails
        thr = 0;
        do_reset();
        chk(fail_o == 1'b0, "R10", "reset clears fail", int'(fail_o), 0);
        pulse_start();
        wait_run(2000);
        chk(level_o == 4'd0 && mode_o == 2'd2, "R5", "run at level 0", int'(level_o), 0);
        repeat (CL + ST + 5) @(negedge clk);
        chk(level_o == 4'd0, "R9", "no drop below 0", int'(level_o), 0);

        // scenario D: one corrupted received vector fails the first pass
        do_reset();
        pulse_start();
        repeat (ST + 5) @(negedge clk);
        rx_flip = 1; @(negedge clk); rx_flip = 0;
        wait_run(2000);
        chk(fail_o == 1'b1 && level_o == 4'hF, "R4", "single rx error fails pass", int'(fail_o), 1);

        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule